// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode code, up to two operand bytes, the two index registers and the address of the following instruction into a 16-bit operand address. It handles several kinds of mode. Direct modes cover page zero, full address and indexed forms. Two indirect modes fetch a pointer from page zero. The relative mode serves branches. The block also reports when the mode costs one more clock cycle.

In the direct and relative modes the result is computed within one clock. In the indirect modes the block drives a read-only memory port itself. It makes two reads back to back: first the pointer's low byte, then its high byte. The memory returns each byte one clock after the address is presented. While the block is working on a pointer it shows busy, and any new request it sees in that time is dropped. The surrounding sequencer issues a request whenever the block is idle and waits for the done pulse. The address and the extra-cycle flag then stay as they are until the next done.

Top module: `ea_gen`

## Requirements
- R1: After reset, done, busy and mem_rd_en are 0 and ea is 0x0000.
- R2: Mode code 0 (page zero) gives ea = {0x00, op_lo} and extra = 0, with done high in the first cycle after the request is accepted.
- R3: Mode codes 1 (page zero plus X) and 2 (page zero plus Y) give ea = {0x00, (op_lo + index) mod 256} and extra = 1, with done in the first cycle after acceptance.
- R4: Mode code 3 (full address) gives ea = {op_hi, op_lo}, so op_lo is the low byte and op_hi the high byte, and extra = 0.
- R5: Mode codes 4 (full plus X) and 5 (full plus Y) give ea = ({op_hi, op_lo} + index) mod 65536. Extra is 1 exactly when op_lo + index exceeds 255.
- R6: Mode code 6 (indexed pointer) reads the bytes at zero-page offsets p = (op_lo + X) mod 256 and then (p + 1) mod 256. It gives ea = {second byte, first byte} and extra = 0.
- R7: Mode code 7 (pointer then Y) reads the bytes at zero-page offsets op_lo and then (op_lo + 1) mod 256. The two bytes form a base, low byte first, and ea = (base + Y) mod 65536. Extra is 1 exactly when the low byte plus Y exceeds 255.
- R8: For codes 6 and 7, mem_rd_en is high in cycles 1 and 2 after acceptance, with mem_addr[15:8] = 0. Each byte is taken one cycle after its address. busy is high in cycles 1 to 3, and done is high in cycle 4 only.
- R9: Mode code 8 (relative) gives ea = (next_pc + sign-extended op_lo) mod 65536 and extra = 0.
- R10: A request presented while busy is high has no effect: the running result, its timing and its reads are unchanged, and no further done appears.
- R11: Mode codes 9 to 15 behave as code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_mode | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte (offset, low address byte or zero-page pointer) |
| op_hi | input | 8 | Second operand byte (high address byte) |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| next_pc | input | 16 | Address of the instruction after the branch |
| mem_rd_en | output | 1 | Pointer read strobe |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid one clock after the address |
| busy | output | 1 | Indirect sequence in progress |
| done | output | 1 | One-cycle result pulse |
| ea | output | 16 | Effective address |
| extra | output | 1 | Mode costs one more cycle |

## Verification
The bench builds the block with the default byte width of 8, which gives the 16-bit address space. With that width, every wrap point can be reached with ordinary byte values. These are the zero-page sums wrapping past 0xFF, the pointer at 0xFF whose high byte comes from 0x00, and page crossings in both indexed full modes and in the pointer-then-Y mode. Branch offsets at both sign extremes are also covered, as is a sum that wraps past 0xFFFF. A behavioural model compares each cycle of every request against the outputs: the read strobe, the read address, busy and the done timing. Requests injected during busy cycles check that they are dropped.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_mode,
  input  logic [BW-1:0] op_lo,
  input  logic [BW-1:0] op_hi,
  input  logic [BW-1:0] idx_x,
  input  logic [BW-1:0] idx_y,
  input  logic [2*BW-1:0] next_pc,
  output logic          mem_rd_en,
  output logic [2*BW-1:0] mem_addr,
  input  logic [BW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [2*BW-1:0] ea,
  output logic          extra
);
  localparam int AW = 2 * BW;
  localparam logic [3:0] M_ZP = 4'd0, M_ZPX = 4'd1, M_ZPY = 4'd2, M_ABS = 4'd3,
                         M_ABX = 4'd4, M_ABY = 4'd5, M_INX = 4'd6, M_INY = 4'd7,
                         M_REL = 4'd8;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_WAIT} st_t;

  st_t            st;
  logic [3:0]     mode_q;
  logic [BW-1:0]  ptr_q, y_q, lo_q;
  logic [AW-1:0]  ea_q;
  logic           done_q, extra_q;

  logic           accept, is_ind;
  logic [AW-1:0]  dir_ea, ind_ea;
  logic           dir_extra, ind_extra;
  logic [BW:0]    abx_lo, aby_lo, iny_lo;

  assign accept    = req_valid && (st == S_IDLE);
  assign is_ind    = (req_mode == M_INX) || (req_mode == M_INY);
  assign abx_lo    = {1'b0, op_lo} + {1'b0, idx_x};
  assign aby_lo    = {1'b0, op_lo} + {1'b0, idx_y};
  assign iny_lo    = {1'b0, lo_q} + {1'b0, y_q};

  always_comb begin
    dir_extra = 1'b0;
    case (req_mode)
      M_ZP:  dir_ea = {{BW{1'b0}}, op_lo};
      M_ZPX: begin dir_ea = {{BW{1'b0}}, BW'(op_lo + idx_x)}; dir_extra = 1'b1; end
      M_ZPY: begin dir_ea = {{BW{1'b0}}, BW'(op_lo + idx_y)}; dir_extra = 1'b1; end
      M_ABX: begin dir_ea = AW'({op_hi, op_lo} + {{BW{1'b0}}, idx_x}); dir_extra = abx_lo[BW]; end
      M_ABY: begin dir_ea = AW'({op_hi, op_lo} + {{BW{1'b0}}, idx_y}); dir_extra = aby_lo[BW]; end
      M_REL: dir_ea = AW'(next_pc + {{BW{op_lo[BW-1]}}, op_lo});
      default: dir_ea = {op_hi, op_lo};
    endcase
  end

  always_comb begin
    if (mode_q == M_INY) begin
      ind_ea    = {BW'(mem_rdata + {{(BW-1){1'b0}}, iny_lo[BW]}), iny_lo[BW-1:0]};
      ind_extra = iny_lo[BW];
    end else begin
      ind_ea    = {mem_rdata, lo_q};
      ind_extra = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= '0;
      ptr_q   <= '0;
      y_q     <= '0;
      lo_q    <= '0;
      ea_q    <= '0;
      done_q  <= 1'b0;
      extra_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          mode_q <= req_mode;
          if (is_ind) begin
            ptr_q <= (req_mode == M_INX) ? BW'(op_lo + idx_x) : op_lo;
            y_q   <= idx_y;
            st    <= S_LO;
          end else begin
            ea_q    <= dir_ea;
            extra_q <= dir_extra;
            done_q  <= 1'b1;
          end
        end
        S_LO: st <= S_HI;
        S_HI: begin
          lo_q <= mem_rdata;
          st   <= S_WAIT;
        end
        default: begin
          ea_q    <= ind_ea;
          extra_q <= ind_extra;
          done_q  <= 1'b1;
          st      <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_rd_en = (st == S_LO) || (st == S_HI);
  assign mem_addr  = {{BW{1'b0}}, (st == S_HI) ? BW'(ptr_q + 1'b1) : ptr_q};
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign ea        = ea_q;
  assign extra     = extra_q;
endmodule

module ea_gen_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd_en,
  input logic [2*BW-1:0] mem_addr,
  input logic          busy,
  input logic          done,
  input logic [2*BW-1:0] ea,
  input logic [3:0]    mode_q
);
  localparam int AW = 2 * BW;

  assert_rd_in_zero_page_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_addr[AW-1:BW] == '0));

  assert_rd_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |=> mem_rd_en);

  assert_rd_only_two_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr[BW-1:0] == BW'($past(mem_addr[BW-1:0]) + 1'b1)));

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_zp_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode_q <= 4'd2)) |-> (ea[AW-1:BW] == '0));
endmodule

bind ea_gen ea_gen_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .busy(busy), .done(done), .ea(ea), .mode_q(mode_q)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_mode = '0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] next_pc = '0;
  logic        mem_rd_en, busy, done, extra;
  logic [15:0] mem_addr, ea;
  logic [7:0]  mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int seed = 12345;

  always #10 clk = ~clk;

  ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .next_pc(next_pc),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea), .extra(extra)
  );

  function automatic int memf(int a);
    return ((a * 37 + 11) ^ (a >> 3)) & 255;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= 8'(memf(int'(mem_addr)));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int m);
    case (m)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input int m, input int lo, input int hi, input int x, input int y,
                     input int pc, input bit noise);
    int e_ea, e_ex, lat, p, b, off;
    string t;
    t = tag_of(m);
    e_ex = 0; lat = 1; p = 0;
    case (m)
      0: e_ea = lo;
      1: begin e_ea = (lo + x) % 256; e_ex = 1; end
      2: begin e_ea = (lo + y) % 256; e_ex = 1; end
      4: begin e_ea = (hi * 256 + lo + x) % 65536; e_ex = (lo + x) > 255; end
      5: begin e_ea = (hi * 256 + lo + y) % 65536; e_ex = (lo + y) > 255; end
      6: begin p = (lo + x) % 256; e_ea = memf(p) + 256 * memf((p + 1) % 256); lat = 4; end
      7: begin
        p = lo;
        b = memf(p) + 256 * memf((p + 1) % 256);
        e_ea = (b + y) % 65536; e_ex = (memf(p) + y) > 255; lat = 4;
      end
      8: begin off = (lo >= 128) ? lo - 256 : lo; e_ea = (pc + off + 65536) % 65536; end
      default: e_ea = hi * 256 + lo;
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'(m); op_lo = 8'(lo); op_hi = 8'(hi);
    idx_x = 8'(x); idx_y = 8'(y); next_pc = 16'(pc);
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      if (noise && c < lat) begin
        req_valid = 1'b1; req_mode = 4'd3; op_lo = 8'h5A; op_hi = 8'hC3;
        idx_x = 8'h77; idx_y = 8'h99;
      end else begin
        req_valid = 1'b0;
      end
      chk(done == (c == lat), (noise ? "R10" : (lat == 4 ? "R8" : t)), int'(done), int'(c == lat));
      if (lat == 4) begin
        chk(busy == (c < 4), "R8", int'(busy), int'(c < 4));
        chk(mem_rd_en == (c <= 2), "R8", int'(mem_rd_en), int'(c <= 2));
        if (c == 1) chk(mem_addr == 16'(p), t, int'(mem_addr), p);
        if (c == 2) chk(mem_addr == 16'((p + 1) % 256), t, int'(mem_addr), (p + 1) % 256);
      end else begin
        chk(!busy && !mem_rd_en, t, int'({busy, mem_rd_en}), 0);
      end
      if (c == lat) begin
        chk(ea == 16'(e_ea), noise ? "R10" : t, int'(ea), e_ea);
        chk(extra == e_ex[0], noise ? "R10" : t, int'(extra), e_ex);
      end
    end
    if (noise) begin
      @(negedge clk);
      chk(!done && !busy, "R10", int'({done, busy}), 0);
    end
  endtask

  function automatic int rnd();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >> 8) & 255;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_rd_en, "R1", int'({done, busy, mem_rd_en}), 0);
    chk(ea == 16'h0000, "R1", int'(ea), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mem_rd_en && ea == 0, "R1", int'(ea), 0);

    run(0, 8'h3C, 8'h12, 0, 0, 0, 0);
    run(1, 8'hF0, 0, 8'h20, 0, 0, 0);
    run(2, 8'hFF, 0, 0, 8'h01, 0, 0);
    run(1, 8'h10, 0, 8'h05, 0, 0, 0);
    run(3, 8'h34, 8'h12, 0, 0, 0, 0);
    run(4, 8'hF0, 8'h12, 8'h20, 0, 0, 0);
    run(4, 8'h10, 8'h12, 8'h20, 0, 0, 0);
    run(5, 8'hFF, 8'hFF, 0, 8'h01, 0, 0);
    run(5, 8'h00, 8'h40, 0, 8'hFF, 0, 0);
    run(6, 8'hF0, 0, 8'h0F, 0, 0, 0);
    run(6, 8'h80, 0, 8'h90, 0, 0, 0);
    run(7, 8'hFF, 0, 0, 8'h10, 0, 0);
    run(7, 8'h22, 0, 0, 8'hFF, 0, 0);
    run(8, 8'h7F, 0, 0, 0, 16'h1000, 0);
    run(8, 8'h80, 0, 0, 0, 16'h1000, 0);
    run(8, 8'hFE, 0, 0, 0, 16'h0001, 0);
    run(8, 8'h05, 0, 0, 0, 16'hFFFE, 0);
    run(9, 8'hCD, 8'hAB, 1, 1, 0, 0);
    run(15, 8'h01, 8'h02, 1, 1, 0, 0);
    run(6, 8'h40, 0, 8'h03, 0, 0, 1);
    run(7, 8'hFF, 0, 0, 8'hC0, 0, 1);

    for (int i = 0; i < 300; i++) begin
      int m;
      m = rnd() % 16;
      run(m, rnd(), rnd(), rnd(), rnd(), rnd() * 256 + rnd(), (i % 7) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule